// File: doc/BRIEF.md
# DMA Interrupt Status, Enable and Control Registers

This block is the interrupt register file of a DMA engine with one transmit and one receive channel. The transmit and receive sequencers and the system-bus interface raise single-cycle event pulses. Each pulse is caught in a sticky status bit. Software clears a status bit by writing 1 to it over a simple register bus.

Each source has its own enable bit. The latched sources fall into two groups, normal and abnormal. Each group has a summary bit in the status word, and each summary bit has its own group enable. The enabled summaries, together with three optional sideband sources, combine into a single interrupt line.

The same status word also shows the live transmit and receive process states and the live sideband levels. A small control register holds the run bits for the two channels.

The bus has four word addresses. Address 0 is the status word, address 1 is the enable register, address 2 is the control register, and address 3 reads as zero. A write takes effect at the clock edge where `bus_wr` is high, and reads are combinational.

Top module: `dma_irq_regs`

## Requirements
- R1: After reset, all latched status bits, the enable register and the control register are zero, and `irq` is low.
- R2: A pulse on `evt_in[i]` (for i from 0 to 10) sets status bit i from the next clock edge on. The bit stays set until software clears it. The source positions are:
  - bit 0: transmit complete
  - bit 1: transmit process stopped
  - bit 2: transmit jabber timeout
  - bit 3: receive overflow
  - bit 4: transmit underflow
  - bit 5: receive complete
  - bit 6: receive buffer unavailable
  - bit 7: receive process stopped
  - bit 8: receive watchdog timeout
  - bit 9: early transmit
  - bit 10: fatal bus error
- R3: Writing the status word clears every latched bit in positions 16..0 whose write-data bit is 1. Bits written as 0 keep their value.
- R4: If an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set. Other bits cleared by that same write still clear.
- R5: Status bit 15 (abnormal summary) is the OR of status bits 1, 2, 3, 4, 6, 7, 8, 9 and 10, counting each only when it is set and its enable bit (the same position in the enable register) is 1.
- R6: Status bit 16 (normal summary) is the OR of status bits 0 and 5, counting each only when it is set and its enable bit is 1.
- R7: `irq` is high exactly when one of these holds:
  - bit 15 is set and enable bit 15 is 1;
  - bit 16 is set and enable bit 16 is 1;
  - a sideband status bit is 1 and its enable bit is 1.
- R8: Status bits 19:17 show `tx_state` and bits 22:20 show `rx_state`, live. Writes to the status word never change these fields.
- R9: Status bits 23, 24 and 25 show `side_in[0]` (line interface), `side_in[1]` (management counters) and `side_in[2]` (power management), live. Writes do not clear them. Each reaches `irq` only through enable bits 23, 24 and 25.
- R10: The enable register (address 1) stores write-data bits 10:0, 15, 16 and 25:23. All its other bits read as zero.
- R11: The control register (address 2) stores bit 0 (transmit run, driven on `tx_run`) and bit 1 (receive run, driven on `rx_run`). Its other bits read as zero.
- R12: Status bits 14:11 and 31:26 read as zero. Address 3 reads as zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| evt_in | input | 11 | Event pulses, one per latched source |
| tx_state | input | 3 | Current transmit process state |
| rx_state | input | 3 | Current receive process state |
| side_in | input | 3 | Optional sideband source levels |
| irq | output | 1 | Interrupt request |
| tx_run | output | 1 | Transmit channel run bit |
| rx_run | output | 1 | Receive channel run bit |

## Verification
Two things can hit the same status bit in one cycle: the sequencer setting it and software clearing it with a write-1. The bench provokes this for every source by driving the pulse and a status write in the same cycle, with the write also clearing a neighbouring bit. It judges the result by reading back the word: the targeted bit must still be set while the neighbour is cleared. Every source is also swept against all eight combinations of its own enable and the two group enables, with the summary bits and `irq` predicted arithmetically from the group membership.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  localparam int DW      = 32;
  localparam int AW      = 2;
  localparam int NSRC    = 11;
  localparam int STW     = 3;
  localparam int NSIDE   = 3;
  localparam int CTW     = 2;

  localparam int B_ABN   = 15;
  localparam int B_NRM   = 16;
  localparam int B_TXST  = 17;
  localparam int B_RXST  = B_TXST + STW;
  localparam int B_SIDE  = B_RXST + STW;
  localparam int W1C_TOP = 16;

  // group membership by latched source position
  localparam logic [NSRC-1:0] GRP_NRM = 11'b000_0010_0001;
  localparam logic [NSRC-1:0] GRP_ABN = 11'b111_1101_1110;

  typedef enum logic [AW-1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  // next value of a sticky bit vector: pulses beat clears
  function automatic logic [NSRC-1:0] sticky_next(
    input logic [NSRC-1:0] cur,
    input logic [NSRC-1:0] clr,
    input logic [NSRC-1:0] pulse);
    return (cur & ~clr) | pulse;
  endfunction

  // any set-and-enabled member of a group
  function automatic logic group_hit(
    input logic [NSRC-1:0] st,
    input logic [NSRC-1:0] en,
    input logic [NSRC-1:0] grp);
    return |(st & en & grp);
  endfunction

  // writable bits of the enable register
  function automatic logic [DW-1:0] en_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < NSRC; i++) m[i] = 1'b1;
    m[B_ABN] = 1'b1;
    m[B_NRM] = 1'b1;
    for (int i = 0; i < NSIDE; i++) m[B_SIDE+i] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/dma_irq_status_bank.sv
module dma_irq_status_bank
  import dma_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pulse_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] st_o
);

  logic [NSRC-1:0] st_d;

  assign st_d = sticky_next(st_o, clr_i, pulse_i);

  for (genvar g = 0; g < NSRC; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_o[g] <= 1'b0;
      else        st_o[g] <= st_d[g];
    end
  end

endmodule

// File: rtl/dma_irq_summary.sv
module dma_irq_summary
  import dma_irq_pkg::*;
(
  input  logic [NSRC-1:0]  st_i,
  input  logic [NSRC-1:0]  en_src_i,
  input  logic             en_abn_i,
  input  logic             en_nrm_i,
  input  logic [NSIDE-1:0] side_i,
  input  logic [NSIDE-1:0] en_side_i,
  output logic             abn_sum_o,
  output logic             nrm_sum_o,
  output logic             irq_o
);

  logic [NSIDE-1:0] side_hit;

  assign abn_sum_o = group_hit(st_i, en_src_i, GRP_ABN);
  assign nrm_sum_o = group_hit(st_i, en_src_i, GRP_NRM);

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    assign side_hit[g] = side_i[g] & en_side_i[g];
  end

  assign irq_o = (abn_sum_o & en_abn_i) | (nrm_sum_o & en_nrm_i) | (|side_hit);

endmodule

// File: rtl/dma_irq_ctl_regs.sv
module dma_irq_ctl_regs
  import dma_irq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  en_q_o,
  output logic [CTW-1:0] ctl_q_o,
  output logic           st_wr_o
);

  localparam logic [DW-1:0] EN_MASK = en_mask();

  logic en_wr, ctl_wr;

  assign st_wr_o = wr_i && (reg_sel_e'(addr_i) == SEL_STATUS);
  assign en_wr   = wr_i && (reg_sel_e'(addr_i) == SEL_ENABLE);
  assign ctl_wr  = wr_i && (reg_sel_e'(addr_i) == SEL_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q_o <= '0;
    else if (en_wr) en_q_o <= wdata_i & EN_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q_o <= '0;
    else if (ctl_wr) ctl_q_o <= wdata_i[CTW-1:0];
  end

endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
  import dma_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NSRC-1:0]   evt_in,
  input  logic [STW-1:0]    tx_state,
  input  logic [STW-1:0]    rx_state,
  input  logic [NSIDE-1:0]  side_in,
  output logic              irq,
  output logic              tx_run,
  output logic              rx_run
);

  // named internal events for the checker
  logic [DW-1:0]   en_q;
  logic [CTW-1:0]  ctl_q;
  logic            st_wr;
  logic [NSRC-1:0] st_clr;
  logic [NSRC-1:0] st_src;
  logic            abn_sum;
  logic            nrm_sum;
  logic [DW-1:0]   status_word;

  dma_irq_ctl_regs i_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (bus_wr),
    .addr_i  (bus_addr),
    .wdata_i (bus_wdata),
    .en_q_o  (en_q),
    .ctl_q_o (ctl_q),
    .st_wr_o (st_wr)
  );

  assign st_clr = st_wr ? bus_wdata[NSRC-1:0] : '0;

  dma_irq_status_bank i_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .pulse_i (evt_in),
    .clr_i   (st_clr),
    .st_o    (st_src)
  );

  dma_irq_summary i_sum (
    .st_i      (st_src),
    .en_src_i  (en_q[NSRC-1:0]),
    .en_abn_i  (en_q[B_ABN]),
    .en_nrm_i  (en_q[B_NRM]),
    .side_i    (side_in),
    .en_side_i (en_q[B_SIDE +: NSIDE]),
    .abn_sum_o (abn_sum),
    .nrm_sum_o (nrm_sum),
    .irq_o     (irq)
  );

  always_comb begin
    status_word                  = '0;
    status_word[NSRC-1:0]        = st_src;
    status_word[B_ABN]           = abn_sum;
    status_word[B_NRM]           = nrm_sum;
    status_word[B_TXST +: STW]   = tx_state;
    status_word[B_RXST +: STW]   = rx_state;
    status_word[B_SIDE +: NSIDE] = side_in;
  end

  always_comb begin
    case (reg_sel_e'(bus_addr))
      SEL_STATUS: bus_rdata = status_word;
      SEL_ENABLE: bus_rdata = en_q;
      SEL_CTRL:   bus_rdata = {{(DW-CTW){1'b0}}, ctl_q};
      default:    bus_rdata = '0;
    endcase
  end

  assign tx_run = ctl_q[0];
  assign rx_run = ctl_q[1];

endmodule

// File: rtl/dma_irq_regs_chk.sv
module dma_irq_regs_chk
  import dma_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_wr,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    bus_rdata,
  input logic [NSRC-1:0]  evt_in,
  input logic [STW-1:0]   tx_state,
  input logic [STW-1:0]   rx_state,
  input logic [NSIDE-1:0] side_in,
  input logic             irq,
  input logic             tx_run,
  input logic             rx_run,
  input logic [NSRC-1:0]  st_src,
  input logic [DW-1:0]    en_q
);

  AST_PULSE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_in != '0) |=> ((st_src & $past(evt_in)) == $past(evt_in))); // R4

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0)
      |=> ((st_src & $past(bus_wdata[NSRC-1:0] & ~evt_in)) == '0)); // R3

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_wr && bus_addr == 2'd0) && evt_in == '0) |=> $stable(st_src)); // R2

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (((|(st_src & en_q[NSRC-1:0])) && (en_q[B_ABN] || en_q[B_NRM]))
             || (|(side_in & en_q[B_SIDE +: NSIDE])))); // R7

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq); // R7

  AST_STATE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> (bus_rdata[B_TXST +: STW] == tx_state
                            && bus_rdata[B_RXST +: STW] == rx_state)); // R8

  AST_RUN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2)
      |=> (tx_run == $past(bus_wdata[0]) && rx_run == $past(bus_wdata[1]))); // R11

endmodule

bind dma_irq_regs dma_irq_regs_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .evt_in    (evt_in),
  .tx_state  (tx_state),
  .rx_state  (rx_state),
  .side_in   (side_in),
  .irq       (irq),
  .tx_run    (tx_run),
  .rx_run    (rx_run),
  .st_src    (st_src),
  .en_q      (en_q)
);

// File: tb/test_dma_irq_regs.sv
module test_dma_irq_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [10:0] evt_in = '0;
  logic [2:0]  tx_state = '0;
  logic [2:0]  rx_state = '0;
  logic [2:0]  side_in = '0;
  logic        irq, tx_run, rx_run;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [10:0] m_src = '0;
  logic [31:0] m_en = '0;

  always #5 clk = ~clk;

  dma_irq_regs i_dma_irq_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
    .tx_state(tx_state), .rx_state(rx_state), .side_in(side_in),
    .irq(irq), .tx_run(tx_run), .rx_run(rx_run)
  );

  // expected status word, built from the requirement text
  function automatic logic [31:0] exp_status(input logic [10:0] s, input logic [31:0] e,
                                             input logic [2:0] t, input logic [2:0] r,
                                             input logic [2:0] sd);
    logic [31:0] w;
    logic abn, nrm;
    abn = 1'b0;
    nrm = 1'b0;
    for (int k = 0; k < 11; k++) begin
      if (k == 0 || k == 5) nrm = nrm | (s[k] & e[k]);
      else                  abn = abn | (s[k] & e[k]);
    end
    w = 32'd0;
    w = w | {21'd0, s};
    w = w | (32'(abn) << 15) | (32'(nrm) << 16);
    w = w | (32'(t) << 17) | (32'(r) << 20) | (32'(sd) << 23);
    return w;
  endfunction

  function automatic logic exp_irq(input logic [31:0] w, input logic [31:0] e);
    return (w[15] & e[15]) | (w[16] & e[16]) | (|(w[25:23] & e[25:23]));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_en(input logic [31:0] d);
    bus_write(2'd1, d);
    m_en = d & 32'h0381_87FF;
  endtask

  task automatic pulse(input logic [10:0] v, input bit with_clr, input logic [31:0] clr);
    @(negedge clk);
    evt_in = v;
    if (with_clr) begin bus_addr = 2'd0; bus_wr = 1'b1; bus_wdata = clr; end
    @(negedge clk);
    evt_in = '0; bus_wr = 1'b0; bus_wdata = '0;
    if (with_clr) m_src = m_src & ~clr[10:0];
    m_src = m_src | v;
  endtask

  task automatic check_status(input string req);
    logic [31:0] d, w;
    bus_read(2'd0, d);
    w = exp_status(m_src, m_en, tx_state, rx_state, side_in);
    chk(req, d, w);
    chk({req, " irq"}, {31'd0, irq}, {31'd0, exp_irq(w, m_en)});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check_status("R1 status after reset");
    bus_read(2'd1, d); chk("R1 enable after reset", d, 32'd0);
    bus_read(2'd2, d); chk("R1 control after reset", d, 32'd0);
    chk("R1 run outputs", {30'd0, rx_run, tx_run}, 32'd0);

    // R2 R3 R5 R6 R7: each source against every enable combination
    for (int i = 0; i < 11; i++) begin
      for (int c = 0; c < 8; c++) begin
        set_en((c[0] ? (32'd1 << i) : 32'd0) | (c[1] ? 32'h8000 : 32'd0)
               | (c[2] ? 32'h1_0000 : 32'd0));
        pulse(11'(1 << i), 1'b0, 32'd0);
        check_status("R2 R5 R6 R7 source latch and summary");
        bus_write(2'd0, 32'd0);
        check_status("R3 zero write keeps bit");
        bus_write(2'd0, 32'd1 << i);
        m_src = m_src & ~11'(1 << i);
        check_status("R3 one write clears bit");
      end
    end

    // R4 pulse and clear in the same cycle
    set_en(32'h0001_87FF);
    for (int i = 0; i < 11; i++) begin
      int j;
      j = (i + 1) % 11;
      pulse(11'(1 << j), 1'b0, 32'd0);
      pulse(11'(1 << i), 1'b1, (32'd1 << i) | (32'd1 << j));
      check_status("R4 pulse beats clear");
      bus_write(2'd0, 32'h0001_FFFF);
      m_src = '0;
      check_status("R4 cleanup");
    end

    // R5 R6 all sources at once, then full clear
    pulse(11'h7FF, 1'b0, 32'd0);
    check_status("R5 R6 all sources");
    bus_write(2'd0, 32'h0001_FFFF);
    m_src = '0;
    check_status("R3 full clear");

    // R8 live state fields, writes do not touch them
    for (int t = 0; t < 8; t++) begin
      tx_state = 3'(t); rx_state = 3'(7 - t);
      check_status("R8 state fields");
      bus_write(2'd0, 32'hFFFF_FFFF);
      check_status("R8 state after write");
    end

    // R9 sideband sources, live and gated by their own enables
    set_en(32'd0);
    for (int s = 0; s < 8; s++) begin
      for (int e = 0; e < 8; e++) begin
        side_in = 3'(s);
        set_en(32'(e) << 23);
        check_status("R9 sideband");
      end
      bus_write(2'd0, 32'hFFFF_FFFF);
      check_status("R9 sideband survives write");
    end
    side_in = '0;

    // R10 enable register writable bits
    set_en(32'hFFFF_FFFF);
    bus_read(2'd1, d); chk("R10 enable all ones", d, 32'h0381_87FF);
    set_en(32'h5A5A_A5A5);
    bus_read(2'd1, d); chk("R10 enable pattern", d, 32'h5A5A_A5A5 & 32'h0381_87FF);

    // R11 control register
    for (int v = 0; v < 4; v++) begin
      bus_write(2'd2, 32'hFFFF_FFFC | 32'(v));
      bus_read(2'd2, d); chk("R11 control readback", d, 32'(v));
      chk("R11 run outputs", {30'd0, rx_run, tx_run}, 32'(v));
    end

    // R12 reserved address and reserved bits
    bus_write(2'd3, 32'hFFFF_FFFF);
    bus_read(2'd3, d); chk("R12 address 3 reads zero", d, 32'd0);
    bus_read(2'd1, d); chk("R12 enable untouched", d, m_en);
    bus_read(2'd2, d); chk("R12 control untouched", d, 32'd3);
    pulse(11'h7FF, 1'b0, 32'd0);
    bus_read(2'd0, d); chk("R12 reserved status bits", d & 32'hFC00_7800, 32'd0);
    check_status("R12 status untouched");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule